// File: doc/BRIEF.md
# AXI Handshake Throughput Monitor

This block listens passively to the valid and ready wires of the five channels of one AXI initiator port. It never sees a data payload. After a start pulse it opens a measurement window that lasts a programmed number of clock cycles. Inside the window it counts completed read and write data beats. It also counts the cycles in which a channel shows VALID while READY stays low. Those stall counts are kept apart per channel: stalls on the address channels come from the interconnect, and stalls on the read data and write response channels come from the logic downstream of the port.

When the window closes, every live count is copied into a set of report registers and a one-cycle done pulse is raised. The live counts then clear. A shared sequential divider turns the data beat total into a utilisation figure in tenths of a percent, and raises a second pulse when that figure is ready. The byte totals are the beat counts multiplied by the data bus width in bytes. Software divides them by the window time to get a rate.

Top module: `axi_tput_mon`

## Requirements
- R1: `rd_beats` reports the number of sampled window cycles in which `rvalid` and `rready` were both high.
- R2: `wr_beats` reports the number of sampled window cycles in which `wvalid` and `wready` were both high.
- R3: `ar_stall` and `aw_stall` report the window cycles in which the address channel's valid was high and its ready was low.
- R4: `r_stall` and `b_stall` report the window cycles in which `rvalid` (or `bvalid`) was high and `rready` (or `bready`) was low.
- R5: If `start` is high in cycle c and is accepted with length L, the window samples the channel wires in cycles c+1 through c+L. `done` is high in cycle c+L+1 only, for exactly one cycle.
- R6: The report outputs keep their values until the next window closes. Every new window counts from zero.
- R7: `rd_bytes` and `wr_bytes` equal the matching beat counts times `BUS_BYTES`. For example, 43 write beats on a 32-byte bus give 1376.
- R8: `util` becomes floor((read beats + write beats) × 1000 / L). `util_valid` pulses for one cycle no more than 32 cycles after `done`. For example, 43 beats in a 50-cycle window give 860.
- R9: `start` is ignored while a window runs, while a utilisation result is pending, or when `win_len` is zero. The length sampled with an accepted `start` holds for the whole window.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to open a window |
| win_len | input | 16 | Window length in cycles, sampled with start |
| arvalid | input | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wvalid | input | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| rvalid | input | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| bvalid | input | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| rd_beats | output | 16 | Read data beats in last window |
| wr_beats | output | 16 | Write data beats in last window |
| ar_stall | output | 16 | Read address stall cycles |
| aw_stall | output | 16 | Write address stall cycles |
| r_stall | output | 16 | Read data stall cycles |
| b_stall | output | 16 | Write response stall cycles |
| rd_bytes | output | 22 | Read bytes in last window |
| wr_bytes | output | 22 | Write bytes in last window |
| util | output | 12 | Utilisation in tenths of a percent |
| done | output | 1 | One-cycle pulse when a window closes |
| util_valid | output | 1 | One-cycle pulse when util is updated |

## Verification
The bench uses the default 32-byte bus. With that width, the 43-beats-in-50-cycles case lands exactly on 1376 bytes and a utilisation of 860. The 16-bit window width is kept, but the windows used are short: one cycle, fifty, two hundred and a few others. This keeps the run brief while still reaching a single-cycle window, a window that counts every cycle on both data channels so the quotient hits its ceiling of 2000, and start pulses that land mid-window, during the divide, and with a zero length.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int WIN_W   = 16;
    localparam int SCALE   = 1000;
    localparam int SCALE_W = 10;
    localparam int NUM_EV  = 6;

    typedef enum logic [2:0] {
        EV_RD_BEAT  = 3'd0,
        EV_WR_BEAT  = 3'd1,
        EV_AR_STALL = 3'd2,
        EV_AW_STALL = 3'd3,
        EV_R_STALL  = 3'd4,
        EV_B_STALL  = 3'd5
    } ev_e;

    typedef struct packed {
        logic valid;
        logic ready;
    } hs_t;

    typedef struct packed {
        hs_t ar;
        hs_t aw;
        hs_t w;
        hs_t r;
        hs_t b;
    } port_hs_t;

    typedef logic [NUM_EV-1:0][WIN_W-1:0] ev_counts_t;

    function automatic logic [NUM_EV-1:0] classify(port_hs_t p);
        logic [NUM_EV-1:0] e;
        e = '0;
        e[EV_RD_BEAT]  = p.r.valid  &  p.r.ready;
        e[EV_WR_BEAT]  = p.w.valid  &  p.w.ready;
        e[EV_AR_STALL] = p.ar.valid & ~p.ar.ready;
        e[EV_AW_STALL] = p.aw.valid & ~p.aw.ready;
        e[EV_R_STALL]  = p.r.valid  & ~p.r.ready;
        e[EV_B_STALL]  = p.b.valid  & ~p.b.ready;
        return e;
    endfunction

endpackage

// File: rtl/tmon_window.sv
module tmon_window
    import tmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIN_W-1:0] win_len,
    input  logic             blocked,
    output logic             active,
    output logic             last,
    output logic [WIN_W-1:0] len_q
);

    logic [WIN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            remain <= '0;
            len_q  <= '0;
        end else if (active) begin
            remain <= remain - 1'b1;
            if (remain == WIN_W'(1)) active <= 1'b0;
        end else if (start && !blocked && win_len != '0) begin
            active <= 1'b1;
            remain <= win_len;
            len_q  <= win_len;
        end
    end

    assign last = active && (remain == WIN_W'(1));

    // R5: an open window counts down by one every cycle
    p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
        (active && !last) |=> (active && remain == $past(remain) - 1'b1));

    // R9: a new start inside a window leaves the length alone
    p_len_held_r9: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(len_q));

    // R9: zero length never opens a window
    p_zero_len_r9: assert property (@(posedge clk) disable iff (rst)
        (!active && win_len == '0) |=> !active);

endmodule

// File: rtl/tmon_counters.sv
module tmon_counters
    import tmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic              last,
    input  logic [NUM_EV-1:0] events,
    output ev_counts_t        totals
);

    ev_counts_t live;

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        always_ff @(posedge clk) begin
            if (rst)            live[i] <= '0;
            else if (sample_en) live[i] <= last ? '0 : live[i] + WIN_W'(events[i]);
        end

        assign totals[i] = live[i] + WIN_W'(events[i]);

        // R6: nothing moves between windows
        p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !sample_en |=> $stable(live[i]));

        // R1: a counter grows by at most one per sampled cycle
        p_single_step_r1: assert property (@(posedge clk) disable iff (rst)
            (sample_en && !last) |=> (live[i] - $past(live[i])) <= WIN_W'(1));
    end

endmodule

// File: rtl/tmon_divider.sv
module tmon_divider #(
    parameter int DVD_W = 27,
    parameter int DVS_W = 16,
    parameter int Q_W   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic             fin,
    output logic [Q_W-1:0]   quot
);

    localparam int STEP_W = $clog2(DVD_W) + 1;

    logic [DVD_W-1:0]  num_sh;
    logic [DVD_W-1:0]  q_acc;
    logic [DVS_W-1:0]  rem;
    logic [DVS_W-1:0]  dvs;
    logic [STEP_W-1:0] step;
    logic [DVS_W:0]    trial;
    logic [DVS_W:0]    diff;
    logic              ge;
    logic [DVD_W-1:0]  q_next;

    always_comb begin
        trial  = {rem, num_sh[DVD_W-1]};
        ge     = trial >= {1'b0, dvs};
        diff   = trial - {1'b0, dvs};
        q_next = {q_acc[DVD_W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            fin    <= 1'b0;
            quot   <= '0;
            num_sh <= '0;
            q_acc  <= '0;
            rem    <= '0;
            dvs    <= '0;
            step   <= '0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                busy   <= 1'b1;
                num_sh <= dividend;
                q_acc  <= '0;
                rem    <= '0;
                dvs    <= divisor;
                step   <= '0;
            end else if (busy) begin
                rem    <= ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
                num_sh <= num_sh << 1;
                q_acc  <= q_next;
                step   <= step + 1'b1;
                if (step == STEP_W'(DVD_W - 1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                    quot <= q_next[Q_W-1:0];
                end
            end
        end
    end

    // R8: partial remainder stays below the divisor
    p_rem_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rem < dvs));

endmodule

// File: rtl/axi_tput_mon.sv
module axi_tput_mon
    import tmon_pkg::*;
#(
    parameter int BUS_BYTES = 32,
    parameter int UTIL_W    = 12,
    parameter int BYTE_W    = WIN_W + $clog2(BUS_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              arvalid,
    input  logic              arready,
    input  logic              awvalid,
    input  logic              awready,
    input  logic              wvalid,
    input  logic              wready,
    input  logic              rvalid,
    input  logic              rready,
    input  logic              bvalid,
    input  logic              bready,
    output logic [WIN_W-1:0]  rd_beats,
    output logic [WIN_W-1:0]  wr_beats,
    output logic [WIN_W-1:0]  ar_stall,
    output logic [WIN_W-1:0]  aw_stall,
    output logic [WIN_W-1:0]  r_stall,
    output logic [WIN_W-1:0]  b_stall,
    output logic [BYTE_W-1:0] rd_bytes,
    output logic [BYTE_W-1:0] wr_bytes,
    output logic [UTIL_W-1:0] util,
    output logic              done,
    output logic              util_valid
);

    localparam int DVD_W = WIN_W + 1 + SCALE_W;

    port_hs_t          port_hs;
    logic [NUM_EV-1:0] events;
    logic              active;
    logic              last;
    logic [WIN_W-1:0]  len_q;
    logic              div_busy;
    ev_counts_t        totals;
    logic [WIN_W:0]    beat_sum;
    logic [DVD_W-1:0]  dividend;

    always_comb begin
        port_hs  = '{ar: '{arvalid, arready}, aw: '{awvalid, awready},
                     w:  '{wvalid,  wready},  r:  '{rvalid,  rready},
                     b:  '{bvalid,  bready}};
        events   = classify(port_hs);
        beat_sum = {1'b0, totals[EV_RD_BEAT]} + {1'b0, totals[EV_WR_BEAT]};
        dividend = DVD_W'(beat_sum) * DVD_W'(SCALE);
    end

    tmon_window u_window (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .win_len (win_len),
        .blocked (div_busy),
        .active  (active),
        .last    (last),
        .len_q   (len_q)
    );

    tmon_counters u_counters (
        .clk       (clk),
        .rst       (rst),
        .sample_en (active),
        .last      (last),
        .events    (events),
        .totals    (totals)
    );

    tmon_divider #(
        .DVD_W (DVD_W),
        .DVS_W (WIN_W),
        .Q_W   (UTIL_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (last),
        .dividend (dividend),
        .divisor  (len_q),
        .busy     (div_busy),
        .fin      (util_valid),
        .quot     (util)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_beats <= '0;
            wr_beats <= '0;
            ar_stall <= '0;
            aw_stall <= '0;
            r_stall  <= '0;
            b_stall  <= '0;
            rd_bytes <= '0;
            wr_bytes <= '0;
            done     <= 1'b0;
        end else begin
            done <= last;
            if (last) begin
                rd_beats <= totals[EV_RD_BEAT];
                wr_beats <= totals[EV_WR_BEAT];
                ar_stall <= totals[EV_AR_STALL];
                aw_stall <= totals[EV_AW_STALL];
                r_stall  <= totals[EV_R_STALL];
                b_stall  <= totals[EV_B_STALL];
                rd_bytes <= BYTE_W'(totals[EV_RD_BEAT]) * BYTE_W'(BUS_BYTES);
                wr_bytes <= BYTE_W'(totals[EV_WR_BEAT]) * BYTE_W'(BUS_BYTES);
            end
        end
    end

    // R5: done lasts a single cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: two data channels can never exceed twice full scale
    p_util_range_r8: assert property (@(posedge clk) disable iff (rst)
        util_valid |-> (util <= UTIL_W'(2 * SCALE)));

    // R9: a result never arrives while a window is open
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        util_valid |-> !active);

endmodule

// File: tb/axi_tput_mon_test.sv
module axi_tput_mon_test;

    localparam int BB = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] win_len = '0;
    logic [9:0]  hs = '0;  // {arv,arr,awv,awr,wv,wr,rv,rr,bv,br}
    logic [15:0] rd_beats, wr_beats, ar_stall, aw_stall, r_stall, b_stall;
    logic [21:0] rd_bytes, wr_bytes;
    logic [11:0] util;
    logic        done, util_valid;

    always #4 clk = ~clk;

    axi_tput_mon #(.BUS_BYTES(BB)) uut (
        .clk(clk), .rst(rst), .start(start), .win_len(win_len),
        .arvalid(hs[9]), .arready(hs[8]), .awvalid(hs[7]), .awready(hs[6]),
        .wvalid(hs[5]), .wready(hs[4]), .rvalid(hs[3]), .rready(hs[2]),
        .bvalid(hs[1]), .bready(hs[0]),
        .rd_beats(rd_beats), .wr_beats(wr_beats), .ar_stall(ar_stall),
        .aw_stall(aw_stall), .r_stall(r_stall), .b_stall(b_stall),
        .rd_bytes(rd_bytes), .wr_bytes(wr_bytes), .util(util),
        .done(done), .util_valid(util_valid)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural reference state
    int    m_acc[6];
    int    e_rep[6];
    bit    m_run, m_pend, exp_done;
    int    m_rem, m_len, m_wait, e_util, e_util_pend;
    string start_req = "R5";

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic compare();
        string rq;
        chk(start_req, "done", done, exp_done);
        rq = exp_done ? "R1" : "R6";
        chk(rq, "rd_beats", rd_beats, e_rep[0]);
        rq = exp_done ? "R2" : "R6";
        chk(rq, "wr_beats", wr_beats, e_rep[1]);
        rq = exp_done ? "R3" : "R6";
        chk(rq, "ar_stall", ar_stall, e_rep[2]);
        chk(rq, "aw_stall", aw_stall, e_rep[3]);
        rq = exp_done ? "R4" : "R6";
        chk(rq, "r_stall", r_stall, e_rep[4]);
        chk(rq, "b_stall", b_stall, e_rep[5]);
        chk("R7", "rd_bytes", rd_bytes, e_rep[0] * BB);
        chk("R7", "wr_bytes", wr_bytes, e_rep[1] * BB);
        if (util_valid) begin
            chk("R8", "util_valid while pending", m_pend, 1);
            e_util = e_util_pend;
            m_pend = 0;
        end else if (m_pend && m_wait > 32) begin
            chk("R8", "util latency", m_wait, 32);
            m_pend = 0;
        end
        chk("R8", "util", util, e_util);
    endtask

    task automatic model(logic st, logic [15:0] ln, logic [9:0] h);
        int ev[6];
        ev[0] = h[3] & h[2];
        ev[1] = h[5] & h[4];
        ev[2] = h[9] & !h[8];
        ev[3] = h[7] & !h[6];
        ev[4] = h[3] & !h[2];
        ev[5] = h[1] & !h[0];
        exp_done = 0;
        if (m_pend) m_wait++;
        if (m_run) begin
            for (int i = 0; i < 6; i++) m_acc[i] += ev[i];
            m_rem--;
            if (m_rem == 0) begin
                for (int i = 0; i < 6; i++) begin
                    e_rep[i] = m_acc[i];
                    m_acc[i] = 0;
                end
                exp_done = 1;
                m_run = 0;
                m_pend = 1;
                m_wait = 0;
                e_util_pend = ((e_rep[0] + e_rep[1]) * 1000) / m_len;
            end
        end else if (!m_pend && st && ln != 0) begin
            m_run = 1;
            m_rem = ln;
            m_len = ln;
        end
    endtask

    task automatic cyc(logic st, logic [15:0] ln, logic [9:0] h);
        @(negedge clk);
        compare();
        start = st;
        win_len = ln;
        hs = h;
        @(posedge clk);
        model(st, ln, h);
    endtask

    task automatic drain();
        for (int k = 0; k < 60 && (m_pend || m_run); k++) cyc(0, 0, '0);
        cyc(0, 0, '0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL R5 watchdog actual %0d expected %0d", cycles, 150000);
                summary();
            end
        end
    end

    initial begin : main
        for (int i = 0; i < 6; i++) begin
            m_acc[i] = 0;
            e_rep[i] = 0;
        end
        m_run = 0; m_pend = 0; exp_done = 0;
        m_rem = 0; m_len = 1; m_wait = 0; e_util = 0; e_util_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset values
        chk("R10", "done", done, 0);
        chk("R10", "util_valid", util_valid, 0);
        chk("R10", "util", util, 0);
        chk("R10", "rd_beats|wr_beats", rd_beats | wr_beats, 0);
        chk("R10", "stalls", ar_stall | aw_stall | r_stall | b_stall, 0);
        chk("R10", "bytes", rd_bytes | wr_bytes, 0);

        // R7/R8 worked case: 43 write beats in 50 cycles -> 860, 1376 bytes
        cyc(1, 50, '0);
        for (int i = 0; i < 50; i++) cyc(0, 0, (i < 43) ? 10'b0000110000 : 10'b0000100000);
        drain();
        chk("R7", "wr_bytes 43 beats", wr_bytes, 1376);
        chk("R8", "util 43 of 50", util, 860);

        // R9: zero length ignored
        start_req = "R9";
        cyc(1, 0, '0);
        repeat (5) cyc(0, 0, 10'b0000110000);
        start_req = "R5";

        // R5: single-cycle window with read beat and response stall
        cyc(1, 1, '0);
        cyc(0, 0, 10'b0000001110);
        drain();

        // R9: start mid-window ignored, length change ignored
        start_req = "R9";
        cyc(1, 200, '0);
        for (int i = 0; i < 200; i++) begin
            logic [9:0] h;
            h = 10'($urandom);
            cyc((i == 100 || i == 150), (i >= 100) ? 16'd7 : 16'd0, h);
        end
        // R9: start held high while the divide is pending
        for (int i = 0; i < 45; i++) cyc(1, 5, 10'($urandom));
        drain();
        start_req = "R5";

        // R8 top of range: both data channels every cycle
        cyc(1, 100, '0);
        for (int i = 0; i < 100; i++) cyc(0, 0, 10'b0000111100);
        drain();
        chk("R8", "util full duplex", util, 2000);

        // R3/R4: all channels valid, none ready
        cyc(1, 30, '0);
        for (int i = 0; i < 30; i++) cyc(0, 0, 10'b1010101010);
        drain();
        chk("R3", "ar_stall all", ar_stall, 30);
        chk("R4", "b_stall all", b_stall, 30);

        // random windows of assorted lengths
        for (int w = 0; w < 4; w++) begin
            int ln;
            ln = 3 + w * 17;
            cyc(1, 16'(ln), '0);
            for (int i = 0; i < ln; i++) cyc(0, 0, 10'($urandom));
            drain();
        end

        summary();
    end

endmodule